// File: doc/BRIEF.md
# Multi-Stream Sequential Line Prefetcher

This block sits beside a second-level cache and looks only at the addresses of that cache's misses. It reduces each address to a 64-byte line number. It then looks for runs of misses to neighbouring lines, where each run may climb or fall. Several runs are followed at once, each in its own slot. Once a run has shown its direction, the block requests the lines that lie just ahead of the latest miss, up to a fixed distance. Each request is a line address for a fill into the second-level cache.

A new miss that matches no slot opens a slot that is not yet confirmed. A second miss to the line directly above or below confirms the run and fixes its direction. Later misses that land inside the lines already requested move the run forward, and lines that were already requested are not asked for again. Every run is limited to the 4 KB page in which it started, so no request ever leaves that page. When every slot is busy, a new run takes the slot that was trained least recently. A single enable input switches the block on or off.

Top module: `seq_line_prefetcher`

## Requirements
- R1: After reset no slot holds a run and no request is presented; a lone miss after reset produces no request.
- R2: A byte address maps to line = address >> 6. Misses in the same line at different byte offsets are the same line. The request port carries a line number, not a byte address.
- R3: After misses to line L and then L+1, the block requests L+2, L+3, L+4 and L+5, in that order and each exactly once.
- R4: After misses to line L and then L-1, the block requests L-2, L-3, L-4 and L-5, in that order and each exactly once.
- R5: A run is confirmed only by a miss to a line adjacent to the run's latest line. Repeated misses to the same line, or misses two or more lines apart, produce no request.
- R6: No request lies outside the 4 KB page of the run, where the page is line >> 6. A run stops at the last line of its page (offset 63 going up, offset 0 going down).
- R7: At most DEPTH (4) lines beyond the latest miss of a run are outstanding as requested lines.
- R8: A miss k lines ahead inside a run's requested window (1 <= k <= DEPTH) moves the run to that line. Only lines not yet requested are then asked for.
- R9: Up to NUM_STREAMS (32) runs in distinct pages and either direction are followed independently. Requests from several runs may interleave.
- R10: When all slots are in use, a miss that matches no run replaces the run trained least recently. A miss to a run's latest line counts as training that run.
- R11: At most one request is presented per cycle. While ready is low, valid stays high and the line stays unchanged.
- R12: While enable is low, misses do not train or open runs and no new request is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; low stops training and new requests |
| miss_valid | input | 1 | A miss address is present this cycle |
| miss_addr | input | ADDR_W (40) | Byte address of the second-level miss |
| pf_valid | output | 1 | Prefetch request present |
| pf_ready | input | 1 | Downstream accepts the request this cycle |
| pf_line | output | LINE_W (34) | Line number to prefetch |

## Verification
The hard case is a miss that trains a run in the same clock edge in which that same run's next line is being launched. The new window must then count the line that left at that edge, so nothing is skipped or sent twice. The bench provokes this by sending two adjacent misses back to back, leaving one idle cycle, and then sending a miss to the first requested line. With ready held high, that third miss meets the second launch exactly. The accepted request stream is judged to be five consecutive lines with no repeat and no gap.

// File: rtl/pfx_pkg.sv
// Shared types for the sequential line prefetcher.
// Assumes: nothing beyond IEEE 1800-2017.
package pfx_pkg;

    // How a miss relates to one slot's run.
    typedef enum logic [2:0] {
        HIT_NONE   = 3'd0,   // unrelated line
        HIT_SAME   = 3'd1,   // miss to the run's latest line
        HIT_ADJ_UP = 3'd2,   // unconfirmed run, line directly above
        HIT_ADJ_DN = 3'd3,   // unconfirmed run, line directly below
        HIT_WIN    = 3'd4    // confirmed run, inside the look-ahead window
    } hit_kind_t;

endpackage

// File: rtl/pfx_pick.sv
// Lowest-index one-hot picker.
// Assumes: N >= 1. Bit 0 has the highest priority.
module pfx_pick #(
    parameter int N = 32
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);

    logic found;

    // Grant the first set request, scanning upward from bit 0.
    always_comb begin
        grant = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/pfx_stream_slot.sv
// One run-tracking slot. It holds the latest miss line, direction, confirm
// flag, the count of lines requested beyond the latest miss, and an LRU age.
// Assumes: sel_alloc and sel_train are never high together. The ages of all
// slots form a permutation of 0..NUM_STREAMS-1. Slots not yet trained keep
// their reset order, so they stay older than any trained slot.
module pfx_stream_slot
    import pfx_pkg::*;
#(
    parameter int LINE_W      = 34,
    parameter int DEPTH       = 4,
    parameter int PAGE_LOG2   = 6,
    parameter int NUM_STREAMS = 32,
    parameter int IDX         = 0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [LINE_W-1:0]              miss_line,
    input  logic                           touch,
    input  logic [$clog2(NUM_STREAMS)-1:0] touch_age,
    input  logic                           sel_train,
    input  logic                           sel_alloc,
    input  logic                           sel_issue,
    output logic                           hit,
    output logic                           want,
    output logic [LINE_W-1:0]              cand_line,
    output logic [$clog2(NUM_STREAMS)-1:0] age
);

    localparam int AH_W  = $clog2(DEPTH + 1);
    localparam int AGE_W = $clog2(NUM_STREAMS);

    logic              valid_q, conf_q, down_q;
    logic [LINE_W-1:0] last_q;
    logic [AH_W-1:0]   ahead_q;
    logic [AGE_W-1:0]  age_q;

    logic [LINE_W-1:0] up_diff, dn_diff, step;
    logic              same_pg;
    hit_kind_t         kind;
    logic [AH_W-1:0]   k_steps, eff_ahead;

    // Classify the incoming miss against this slot's run.
    always_comb begin
        up_diff = miss_line - last_q;
        dn_diff = last_q - miss_line;
        step    = down_q ? dn_diff : up_diff;
        same_pg = miss_line[LINE_W-1:PAGE_LOG2] == last_q[LINE_W-1:PAGE_LOG2];
        kind    = HIT_NONE;
        if (valid_q) begin
            if (miss_line == last_q)
                kind = HIT_SAME;
            else if (!conf_q && same_pg && up_diff == LINE_W'(1))
                kind = HIT_ADJ_UP;
            else if (!conf_q && same_pg && dn_diff == LINE_W'(1))
                kind = HIT_ADJ_DN;
            else if (conf_q && same_pg && step != '0 && step <= LINE_W'(DEPTH))
                kind = HIT_WIN;
        end
        k_steps   = step[AH_W-1:0];
        eff_ahead = ahead_q + AH_W'(sel_issue);
    end

    // Next line to request, and whether it is still allowed.
    always_comb begin
        cand_line = down_q ? last_q - (LINE_W'(ahead_q) + LINE_W'(1))
                           : last_q + (LINE_W'(ahead_q) + LINE_W'(1));
        want = valid_q && conf_q && (ahead_q < AH_W'(DEPTH)) &&
               (cand_line[LINE_W-1:PAGE_LOG2] == last_q[LINE_W-1:PAGE_LOG2]);
    end

    assign hit = kind != HIT_NONE;
    assign age = age_q;

    // Run state: open, confirm, advance, or count a launched line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            conf_q  <= 1'b0;
            down_q  <= 1'b0;
            last_q  <= '0;
            ahead_q <= '0;
        end else if (sel_alloc) begin
            valid_q <= 1'b1;
            conf_q  <= 1'b0;
            down_q  <= 1'b0;
            last_q  <= miss_line;
            ahead_q <= '0;
        end else if (sel_train) begin
            case (kind)
                HIT_ADJ_UP, HIT_ADJ_DN: begin
                    conf_q  <= 1'b1;
                    down_q  <= (kind == HIT_ADJ_DN);
                    last_q  <= miss_line;
                    ahead_q <= '0;
                end
                HIT_WIN: begin
                    last_q  <= miss_line;
                    ahead_q <= (eff_ahead > k_steps) ? eff_ahead - k_steps : '0;
                end
                default: ahead_q <= eff_ahead;
            endcase
        end else begin
            ahead_q <= eff_ahead;
        end
    end

    // LRU age: a touched slot becomes youngest, and younger slots age by one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            age_q <= AGE_W'(IDX);
        else if (sel_alloc || sel_train)
            age_q <= '0;
        else if (touch && age_q < touch_age)
            age_q <= age_q + AGE_W'(1);
    end

    // R7: never more than DEPTH lines counted ahead of the latest miss.
    assert_window_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ahead_q <= AH_W'(DEPTH));

endmodule

// File: rtl/seq_line_prefetcher.sv
// Multi-stream sequential line prefetcher. It trains slots on miss lines,
// picks one wanting slot per cycle, and registers the request until accepted.
// Assumes: NUM_STREAMS >= 2 and a power of two. PAGE_BYTES is a multiple of
// LINE_BYTES. The lowest-index slot wins among matches and among wanting slots.
module seq_line_prefetcher #(
    parameter int ADDR_W      = 40,
    parameter int LINE_BYTES  = 64,
    parameter int PAGE_BYTES  = 4096,
    parameter int NUM_STREAMS = 32,
    parameter int DEPTH       = 4,
    parameter int LINE_W      = ADDR_W - $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [LINE_W-1:0] pf_line
);

    localparam int LINE_SHIFT = $clog2(LINE_BYTES);
    localparam int PAGE_LOG2  = $clog2(PAGE_BYTES / LINE_BYTES);
    localparam int AGE_W      = $clog2(NUM_STREAMS);

    logic [LINE_W-1:0]      miss_line;
    logic                   unused_offset;
    logic                   train_go, any_hit, touch, can_load, any_want, load;
    logic [NUM_STREAMS-1:0] hit_vec, want_vec, victim_vec;
    logic [NUM_STREAMS-1:0] train_oh, alloc_oh, touch_oh, issue_grant, issue_oh;
    logic [LINE_W-1:0]      cand_arr [NUM_STREAMS];
    logic [AGE_W-1:0]       age_arr  [NUM_STREAMS];
    logic [AGE_W-1:0]       touch_age;
    logic [LINE_W-1:0]      sel_line;
    logic                   pf_valid_q;
    logic [LINE_W-1:0]      pf_line_q;

    assign miss_line     = miss_addr[ADDR_W-1:LINE_SHIFT];
    assign unused_offset = ^miss_addr[LINE_SHIFT-1:0];
    assign train_go      = enable && miss_valid;

    // One slot per tracked run.
    for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_slot
        pfx_stream_slot #(
            .LINE_W     (LINE_W),
            .DEPTH      (DEPTH),
            .PAGE_LOG2  (PAGE_LOG2),
            .NUM_STREAMS(NUM_STREAMS),
            .IDX        (g)
        ) i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .miss_line (miss_line),
            .touch     (touch),
            .touch_age (touch_age),
            .sel_train (train_oh[g]),
            .sel_alloc (alloc_oh[g]),
            .sel_issue (issue_oh[g]),
            .hit       (hit_vec[g]),
            .want      (want_vec[g]),
            .cand_line (cand_arr[g]),
            .age       (age_arr[g])
        );
        assign victim_vec[g] = age_arr[g] == AGE_W'(NUM_STREAMS - 1);
    end

    pfx_pick #(.N(NUM_STREAMS)) i_hit_pick (
        .req   (hit_vec & {NUM_STREAMS{train_go}}),
        .grant (train_oh),
        .any   (any_hit)
    );

    pfx_pick #(.N(NUM_STREAMS)) i_issue_pick (
        .req   (want_vec),
        .grant (issue_grant),
        .any   (any_want)
    );

    assign alloc_oh = victim_vec & {NUM_STREAMS{train_go && !any_hit}};
    assign touch_oh = train_oh | alloc_oh;
    assign touch    = |touch_oh;
    assign can_load = enable && (!pf_valid_q || pf_ready);
    assign load     = can_load && any_want;
    assign issue_oh = issue_grant & {NUM_STREAMS{can_load}};

    // Gather the touched slot's age and the chosen slot's line.
    always_comb begin
        touch_age = '0;
        sel_line  = '0;
        for (int i = 0; i < NUM_STREAMS; i++) begin
            if (touch_oh[i]) touch_age = touch_age | age_arr[i];
            if (issue_oh[i]) sel_line  = sel_line | cand_arr[i];
        end
    end

    // Output register: hold while stalled, reload when free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid_q <= 1'b0;
            pf_line_q  <= '0;
        end else begin
            if (pf_valid_q && pf_ready) pf_valid_q <= 1'b0;
            if (load) begin
                pf_valid_q <= 1'b1;
                pf_line_q  <= sel_line;
            end
        end
    end

    assign pf_valid = pf_valid_q;
    assign pf_line  = pf_line_q;

    // R11: a stalled request keeps valid and line.
    assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid_q && !pf_ready) |=> (pf_valid_q && $stable(pf_line_q)));

    // R12: while disabled and idle, no request appears.
    assert_idle_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !pf_valid_q) |=> !pf_valid_q);

    // R10: ages stay a permutation, so exactly one slot is the oldest.
    assert_single_victim_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(victim_vec));

    // R9: at most one slot launches a line per cycle.
    assert_one_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_oh));

endmodule

// File: tb/test_seq_line_prefetcher.sv
// Directed bench: one task per scenario, each checking its own results.
module test_seq_line_prefetcher;

    logic        clk = 1'b0;
    logic        rst_n, enable, miss_valid, pf_valid, pf_ready;
    logic [39:0] miss_addr;
    logic [33:0] pf_line;

    always #2 clk = ~clk;   // 250 MHz

    seq_line_prefetcher i_seq_line_prefetcher (
        .clk(clk), .rst_n(rst_n), .enable(enable), .miss_valid(miss_valid),
        .miss_addr(miss_addr), .pf_valid(pf_valid), .pf_ready(pf_ready),
        .pf_line(pf_line)
    );

    longint got[$];
    int     checks = 0;
    int     errors = 0;
    bit     done   = 1'b0;

    // Memory stub: records every accepted line (stable at the falling edge).
    always @(negedge clk)
        if (rst_n && pf_valid && pf_ready) got.push_back(longint'(pf_line));

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint ln(longint page, longint off);
        return page * 64 + off;
    endfunction

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic miss(longint line, int byte_off);
        miss_addr  = (40'(line) << 6) | 40'(byte_off);
        miss_valid = 1'b1;
        @(posedge clk); #1;
        miss_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    // Expects q to hold exactly n lines first, first+dir, ...
    task automatic expect_run(string req, longint q[$], longint first, int n, int dir);
        check(q.size() == n, req, "request count", q.size(), n);
        for (int i = 0; i < n && i < q.size(); i++)
            check(q[i] == first + dir * i, req, "request line", q[i], first + dir * i);
    endtask

    function automatic void page_filter(longint page, ref longint src[$], ref longint dst[$]);
        dst.delete();
        foreach (src[i]) if ((src[i] >> 6) == page) dst.push_back(src[i]);
    endfunction

    task automatic t_reset();   // R1
        check(pf_valid == 1'b0, "R1", "valid after reset", pf_valid, 0);
        got.delete();
        miss(ln(199, 7), 0);
        idle(10);
        check(got.size() == 0, "R1", "lone miss requests", got.size(), 0);
    endtask

    task automatic t_ascend();  // R3, R2 (byte offsets ignored, line output)
        got.delete();
        miss(ln(200, 10), 'h13);
        miss(ln(200, 11), 'h3F);
        idle(14);
        expect_run("R3", got, ln(200, 12), 4, 1);
        check(got.size() > 0 && got[0] == ln(200, 12), "R2", "line not byte address",
              got.size() > 0 ? got[0] : -1, ln(200, 12));
    endtask

    task automatic t_descend(); // R4
        got.delete();
        miss(ln(201, 40), 0);
        miss(ln(201, 39), 5);
        idle(14);
        expect_run("R4", got, ln(201, 38), 4, -1);
    endtask

    task automatic t_unconfirmed(); // R5, R2
        got.delete();
        miss(ln(202, 10), 0);
        miss(ln(202, 10), 32);
        miss(ln(202, 12), 0);
        idle(12);
        check(got.size() == 0, "R5", "same line / gap confirmed", got.size(), 0);
    endtask

    task automatic t_page();    // R6
        got.delete();
        miss(ln(203, 60), 0);
        miss(ln(203, 61), 0);
        idle(12);
        expect_run("R6", got, ln(203, 62), 2, 1);
        got.delete();
        miss(ln(204, 3), 0);
        miss(ln(204, 2), 0);
        idle(12);
        expect_run("R6", got, ln(204, 1), 2, -1);
    endtask

    task automatic t_window();  // R8, R7
        miss(ln(205, 10), 0);
        miss(ln(205, 11), 0);
        idle(14);
        got.delete();
        miss(ln(205, 13), 0);
        idle(12);
        expect_run("R8", got, ln(205, 16), 2, 1);
        got.delete();
        miss(ln(205, 14), 0);
        idle(12);
        expect_run("R7", got, ln(205, 18), 1, 1);
    endtask

    task automatic t_multi();   // R9
        longint sub[$];
        got.delete();
        miss(ln(206, 20), 0);
        miss(ln(207, 50), 0);
        miss(ln(206, 21), 0);
        miss(ln(207, 49), 0);
        idle(20);
        check(got.size() == 8, "R9", "total requests", got.size(), 8);
        page_filter(206, got, sub);
        expect_run("R9", sub, ln(206, 22), 4, 1);
        page_filter(207, got, sub);
        expect_run("R9", sub, ln(207, 48), 4, -1);
    endtask

    task automatic t_hold();    // R11
        got.delete();
        pf_ready = 1'b0;
        miss(ln(208, 10), 0);
        miss(ln(208, 11), 0);
        idle(3);
        @(negedge clk);
        check(pf_valid == 1'b1 && longint'(pf_line) == ln(208, 12), "R11", "stalled line",
              longint'(pf_line), ln(208, 12));
        idle(4);
        @(negedge clk);
        check(pf_valid == 1'b1 && longint'(pf_line) == ln(208, 12), "R11", "still held",
              longint'(pf_line), ln(208, 12));
        @(posedge clk); #1;
        pf_ready = 1'b1;
        idle(12);
        expect_run("R11", got, ln(208, 12), 4, 1);
    endtask

    task automatic t_collide(); // training meets a launch on the same run (R8)
        got.delete();
        miss(ln(209, 10), 0);
        miss(ln(209, 11), 0);
        idle(1);
        miss(ln(209, 12), 0);
        idle(14);
        expect_run("R8", got, ln(209, 12), 5, 1);
    endtask

    task automatic t_enable();  // R12
        got.delete();
        enable = 1'b0;
        miss(ln(210, 10), 0);
        miss(ln(210, 11), 0);
        idle(10);
        check(got.size() == 0, "R12", "requests while off", got.size(), 0);
        check(pf_valid == 1'b0, "R12", "valid while off", pf_valid, 0);
        enable = 1'b1;
        miss(ln(210, 12), 0);
        idle(10);
        check(got.size() == 0, "R12", "misses trained while off", got.size(), 0);
    endtask

    task automatic t_lru();     // R10
        do_reset();
        for (int i = 0; i < 32; i++) miss(ln(300 + i, 5), 0);
        miss(ln(300, 5), 0);   // refresh the first run
        miss(ln(400, 5), 0);   // evicts the run in page 301
        got.delete();
        miss(ln(400, 6), 0);
        idle(12);
        expect_run("R10", got, ln(400, 7), 4, 1);
        got.delete();
        miss(ln(300, 6), 0);
        idle(12);
        expect_run("R10", got, ln(300, 7), 4, 1);
        got.delete();
        miss(ln(301, 6), 0);
        idle(12);
        check(got.size() == 0, "R10", "evicted run still alive", got.size(), 0);
    endtask

    initial begin
        rst_n = 1'b0; enable = 1'b1; miss_valid = 1'b0; miss_addr = '0; pf_ready = 1'b1;
        do_reset();
        t_reset();
        t_ascend();
        t_descend();
        t_unconfirmed();
        t_page();
        t_window();
        t_multi();
        t_hold();
        t_collide();
        t_enable();
        t_lru();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule